// File: doc/BRIEF.md
# Test Status Pin and Retire Watchdog

This block owns one test-status output pin and a watchdog on instruction retirement. The pin reports the outcome of the instruction-cache built-in self-test. It goes high when a self-test starts. It drops when the test completes with a pass, and it stays high when the test fails. Separately, a counter watches the retire indication. If that input stays low for a full threshold of consecutive cycles, the block issues a one-cycle reset request and shows the event on the same pin as a fixed-width high pulse.

The pin is modelled as an open-drain style pair: an output enable together with a data level. The enable is active only while the level is high. When a timeout pulse ends, the pin returns to the level held by the self-test result. The threshold and the pulse width are parameters. The defaults are one billion cycles and 256 cycles, and a testbench can shrink both. The self-test engine, the pad and any reset sequencing downstream are outside this block.

Top module: `tstat_pin_ctrl`

## Requirements
- R1: While `rst_n` is low the pin level, the enable and the reset request are all low, and on release every counter and the self-test record start cleared.
- R2: A cycle with `bist_start_i` high makes the pin high from the next cycle on, and the pin stays high while the self-test is running.
- R3: `bist_done_i` with `bist_pass_i` high, while a self-test is running, makes the self-test contribution to the pin low from the next cycle.
- R4: `bist_done_i` with `bist_pass_i` low, while a self-test is running, keeps the pin high until the next start or reset.
- R5: After `TIMEOUT_CYCLES` consecutive clock edges at which `retire_i` is low (and no self-test is running or starting), `wdog_rst_req_o` is high for exactly one cycle, and counting then restarts from zero.
- R6: Any edge with `retire_i` high clears the idle count, so idle cycles must be consecutive to cause a timeout.
- R7: The idle count is held at zero while a self-test is running and on the cycle of a start strobe.
- R8: A timeout drives the pin high for exactly `PULSE_CYCLES` cycles, starting in the same cycle as the reset request.
- R9: When the pulse ends, the pin returns to the self-test level: low if the test passed or was never run, high if it failed.
- R10: A timeout during an active pulse reloads the pulse, which then lasts `PULSE_CYCLES` cycles from the new request.
- R11: `stat_oe_o` equals `stat_lvl_o` in every cycle. The pin is driven only when high.
- R12: `bist_done_i` has no effect when no self-test is running. When start and done arrive in the same cycle, the start wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bist_start_i | input | 1 | Self-test start strobe |
| bist_done_i | input | 1 | Self-test completion strobe |
| bist_pass_i | input | 1 | Result flag, read with done (1 = pass) |
| retire_i | input | 1 | High in each cycle an instruction retires |
| stat_oe_o | output | 1 | Pin output enable, high only while driving high |
| stat_lvl_o | output | 1 | Pin data level |
| wdog_rst_req_o | output | 1 | One-cycle watchdog reset request |

## Verification
The bench shrinks the threshold below the pulse width. This lets a second timeout land inside a live pulse. A design that did not reload the pulse would drop the pin early. Long idle stretches run during a self-test and across a single retire just before the threshold. A watchdog that kept counting there would raise a request too early. A done strobe arrives with no test running, and another arrives on the same cycle as a start. A design that took either one would change the latched result. After every pulse the bench checks that the pin falls back to the latched pass or fail level, not to a fixed low.

// File: rtl/tstat_pkg.sv
// Package: shared types and sizing helpers for the test-status pin block.
// Assumes thresholds and widths are at least 1.
package tstat_pkg;

    // Self-test record held between start and the next start or reset
    typedef enum logic [1:0] {
        BIST_CLEAN   = 2'd0,  // passed, or never run
        BIST_RUNNING = 2'd1,  // started, result pending
        BIST_FAILED  = 2'd2   // completed with a failure
    } bist_state_e;

    // Width of a counter that must hold values 0..n-1
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/tstat_bist_tracker.sv
// Module: tracks the instruction-cache self-test and keeps its outcome.
// Start always wins; done only counts while a test is running.
// Assumes start/done are single-cycle strobes from the self-test engine.
module tstat_bist_tracker
    import tstat_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        done_i,
    input  logic        pass_i,
    output bist_state_e state_o,
    output logic        running_o,
    output logic        level_hi_o
);

    bist_state_e state_q;

    // Purpose: advance the self-test record on start and completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BIST_CLEAN;
        end else if (start_i) begin
            state_q <= BIST_RUNNING;
        end else if (done_i && (state_q == BIST_RUNNING)) begin
            state_q <= pass_i ? BIST_CLEAN : BIST_FAILED;
        end
    end

    // Purpose: expose the record and the level it asks of the pin
    always_comb begin
        state_o    = state_q;
        running_o  = (state_q == BIST_RUNNING);
        level_hi_o = (state_q != BIST_CLEAN);
    end

endmodule

// File: rtl/tstat_retire_wdog.sv
// Module: counts consecutive cycles without an instruction retiring.
// Emits a one-cycle registered request once TIMEOUT_CYCLES idle edges have
// been seen, then restarts from zero. Retire or hold clears the count.
// Assumes TIMEOUT_CYCLES >= 2.
module tstat_retire_wdog
    import tstat_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYCLES = 1_000_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic retire_i,
    input  logic hold_i,
    output logic timeout_o
);

    localparam int unsigned CW = cnt_width(TIMEOUT_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYCLES - 1);

    logic [CW-1:0] idle_q;
    logic          fire_q;
    logic          at_last;

    // Purpose: detect the final idle edge before the threshold
    always_comb begin
        at_last = (idle_q == LAST);
    end

    // Purpose: idle counter with clear on retire, hold or expiry
    always_ff @(posedge clk) begin
        if (!rst_n || retire_i || hold_i) begin
            idle_q <= '0;
            fire_q <= 1'b0;
        end else if (at_last) begin
            idle_q <= '0;
            fire_q <= 1'b1;
        end else begin
            idle_q <= idle_q + 1'b1;
            fire_q <= 1'b0;
        end
    end

    assign timeout_o = fire_q;

endmodule

// File: rtl/tstat_pulse_gen.sv
// Module: stretches a timeout strobe into a fixed-width high pulse.
// The pulse is visible in the cycle the strobe is high; a new strobe
// reloads the full width. Assumes the trigger is a registered strobe.
module tstat_pulse_gen
    import tstat_pkg::*;
#(
    parameter int unsigned PULSE_CYCLES = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger_i,
    output logic pulse_o
);

    localparam int unsigned PW = cnt_width(PULSE_CYCLES);

    generate
        if (PULSE_CYCLES <= 1) begin : g_single
            // Purpose: a width of one is the strobe itself
            assign pulse_o = trigger_i;
        end else begin : g_count
            localparam logic [PW-1:0] RELOAD = PW'(PULSE_CYCLES - 1);
            logic [PW-1:0] left_q;
            logic          tail_q;

            // Purpose: count down the cycles of the pulse after the strobe
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    left_q <= '0;
                    tail_q <= 1'b0;
                end else if (trigger_i) begin
                    left_q <= RELOAD;
                    tail_q <= 1'b1;
                end else if (left_q > 1) begin
                    left_q <= left_q - 1'b1;
                    tail_q <= 1'b1;
                end else begin
                    left_q <= '0;
                    tail_q <= 1'b0;
                end
            end

            assign pulse_o = trigger_i | tail_q;
        end
    endgenerate

endmodule

// File: rtl/tstat_pin_ctrl.sv
// Module: test-status pin controller with the retire watchdog.
// Combines the self-test record and the timeout pulse onto one pin.
// Priority: reset, then the timeout pulse, then the self-test level.
// The pin is an open-drain style pair: enable only while driving high.
// Assumes all inputs are synchronous to clk.
module tstat_pin_ctrl
    import tstat_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYCLES = 1_000_000_000,
    parameter int unsigned PULSE_CYCLES   = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bist_start_i,
    input  logic bist_done_i,
    input  logic bist_pass_i,
    input  logic retire_i,
    output logic stat_oe_o,
    output logic stat_lvl_o,
    output logic wdog_rst_req_o
);

    bist_state_e bist_state;
    logic        bist_running;
    logic        bist_hi;
    logic        wdog_fire;
    logic        pulse_on;
    logic        wdog_hold;
    logic        pin_level;

    tstat_bist_tracker u_bist (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (bist_start_i),
        .done_i     (bist_done_i),
        .pass_i     (bist_pass_i),
        .state_o    (bist_state),
        .running_o  (bist_running),
        .level_hi_o (bist_hi)
    );

    // Purpose: freeze the watchdog while a self-test runs or begins
    assign wdog_hold = bist_running | bist_start_i;

    tstat_retire_wdog #(
        .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
    ) u_wdog (
        .clk       (clk),
        .rst_n     (rst_n),
        .retire_i  (retire_i),
        .hold_i    (wdog_hold),
        .timeout_o (wdog_fire)
    );

    tstat_pulse_gen #(
        .PULSE_CYCLES (PULSE_CYCLES)
    ) u_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .trigger_i (wdog_fire),
        .pulse_o   (pulse_on)
    );

    // Purpose: prioritised pin level selection
    always_comb begin
        if (!rst_n)        pin_level = 1'b0;
        else if (pulse_on) pin_level = 1'b1;
        else               pin_level = bist_hi;
    end

    // Purpose: drive the open-drain style pair and the reset request
    always_comb begin
        stat_lvl_o     = pin_level;
        stat_oe_o      = pin_level;
        wdog_rst_req_o = rst_n & wdog_fire;
    end

endmodule

// File: rtl/tstat_pin_ctrl_chk.sv
// Module: assertion checker for tstat_pin_ctrl, attached by bind below.
// Observes ports plus the running flag and pulse state of the top.
module tstat_pin_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic bist_start_i,
    input logic bist_done_i,
    input logic bist_pass_i,
    input logic retire_i,
    input logic stat_lvl_o,
    input logic wdog_rst_req_o,
    input logic bist_running,
    input logic pulse_on
);

    AST_REQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_rst_req_o |=> !wdog_rst_req_o); // R5

    AST_RETIRE_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        retire_i |=> !wdog_rst_req_o); // R6

    AST_START_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        bist_start_i |=> !wdog_rst_req_o); // R7

    AST_REQ_RAISES_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_rst_req_o |-> stat_lvl_o); // R8

    AST_START_RAISES_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        bist_start_i |=> stat_lvl_o); // R2

    AST_PASS_RELEASES_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (bist_running && bist_done_i && bist_pass_i && !bist_start_i)
        |=> (!stat_lvl_o || pulse_on)); // R3

endmodule

bind tstat_pin_ctrl tstat_pin_ctrl_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .bist_start_i   (bist_start_i),
    .bist_done_i    (bist_done_i),
    .bist_pass_i    (bist_pass_i),
    .retire_i       (retire_i),
    .stat_lvl_o     (stat_lvl_o),
    .wdog_rst_req_o (wdog_rst_req_o),
    .bist_running   (bist_running),
    .pulse_on       (pulse_on)
);

// File: tb/tstat_pin_ctrl_tb.sv
// Bench: directed corners plus seeded random traffic, compared each cycle
// with a reference model written from the requirements.
module tstat_pin_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int TMO        = 10;
    localparam int PLS        = 16;
    localparam int WDOG_LIMIT = 200000;

    logic clk = 1'b0;
    logic rst_n, st, dn, ps, rt;
    logic oe, lvl, req;

    int checks = 0;
    int failures = 0;
    string tag = "R1";

    // reference model state: 0 clean, 1 running, 2 failed
    int m_state, m_idle, m_pulse;
    logic m_req, m_rst;

    tstat_pin_ctrl #(.TIMEOUT_CYCLES(TMO), .PULSE_CYCLES(PLS)) u_dut (
        .clk(clk), .rst_n(rst_n), .bist_start_i(st), .bist_done_i(dn),
        .bist_pass_i(ps), .retire_i(rt), .stat_oe_o(oe), .stat_lvl_o(lvl),
        .wdog_rst_req_o(req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic exp_level();
        if (!m_rst) return 1'b0;
        return (m_pulse > 0) || (m_state != 0);
    endfunction

    function automatic logic exp_req();
        return m_rst && m_req;
    endfunction

    task automatic check_bit(string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        check_bit("level", lvl, exp_level());
        check_bit("oe", oe, exp_level());   // R11
        check_bit("req", req, exp_req());
    endtask

    // one cycle: compare at negedge, drive, then advance model at posedge
    task automatic step(logic r, logic s, logic d, logic p, logic t);
        logic hold;
        @(negedge clk);
        compare();
        rst_n = r; st = s; dn = d; ps = p; rt = t;
        @(posedge clk);
        m_rst = r;
        if (!r) begin
            m_state = 0; m_idle = 0; m_pulse = 0; m_req = 1'b0;
        end else begin
            hold = s || (m_state == 1);
            if (hold || t) begin
                m_idle = 0; m_req = 1'b0;
            end else if (m_idle == TMO - 1) begin
                m_idle = 0; m_req = 1'b1;
            end else begin
                m_idle++; m_req = 1'b0;
            end
            if (m_req) m_pulse = PLS;
            else if (m_pulse > 0) m_pulse--;
            if (s) m_state = 1;
            else if (d && m_state == 1) m_state = p ? 0 : 2;
        end
    endtask

    task automatic idle(int n, logic t);
        for (int i = 0; i < n; i++) step(1, 0, 0, 0, t);
    endtask

    initial begin
        #(CLK_PERIOD * WDOG_LIMIT);
        failures++;
        $display("FAIL watchdog expired at %0t", $time);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2024);
        rst_n = 0; st = 0; dn = 0; ps = 0; rt = 0;
        m_state = 0; m_idle = 0; m_pulse = 0; m_req = 0; m_rst = 0;

        tag = "R1";
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 1);
        step(1, 0, 0, 0, 1);

        tag = "R2_R7";   // start, long run with no retire, no timeout
        step(1, 1, 0, 0, 0);
        idle(3 * TMO, 0);

        tag = "R3";      // pass releases the pin
        step(1, 0, 1, 1, 0);
        idle(3, 1);

        tag = "R6";      // retire one cycle before threshold
        idle(TMO - 1, 0);
        step(1, 0, 0, 0, 1);
        idle(TMO - 1, 0);

        tag = "R5_R8";   // completes timeout, pulse runs
        idle(1, 0);
        idle(4, 1);

        tag = "R10";     // second timeout inside live pulse
        idle(TMO, 0);
        idle(PLS + 4, 1);

        tag = "R9";      // fail latched, pulse ends back high
        step(1, 1, 0, 0, 0);
        step(1, 0, 1, 0, 0);
        idle(TMO + PLS + 3, 0);
        idle(3, 1);

        tag = "R4";      // fail held until next start
        idle(5, 1);

        tag = "R12";     // stray done, then start with done
        step(1, 1, 1, 1, 1);
        idle(2, 1);
        step(1, 0, 1, 1, 1);
        idle(2, 1);
        step(1, 0, 1, 0, 1);
        idle(2, 1);

        tag = "R1";      // reset mid-pulse
        idle(TMO + 2, 0);
        step(0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 1);
        idle(2, 1);

        tag = "R5_R9_random";
        for (int i = 0; i < 4000; i++) begin
            logic r, s, d, p, t;
            r = ($urandom_range(0, 499) != 0);
            s = ($urandom_range(0, 99) == 0);
            d = ($urandom_range(0, 29) == 0);
            p = ($urandom_range(0, 1) == 0);
            t = ($urandom_range(0, 99) < 4);
            step(r, s, d, p, t);
        end
        @(negedge clk);
        compare();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule